// File: doc/BRIEF.md
# Hardware Page-Table Walker

This block resolves translation misses from a TLB with no help from software. A miss request carries a virtual page number and a flag that says whether the access is speculative. The block reads entries of a two-level radix page table through a simple memory request/response port. It then reports one result per request: a translation fill for the TLB, a fault, or a mis-speculation. The top level of the table is a directory page whose frame number is given on an input. Each present directory entry names the frame of a second-level table. Each present second-level (leaf) entry names the physical frame of the page.

Two walks can run at the same time. Each walk owns one walk slot, and the slot index is also the tag it puts on memory requests, so responses for the two walks may return in either order. A small, fully associative cache keeps present directory entries, so a later walk through the same directory slot skips the first read. Entries that are not present are never kept, at either level. A flush input empties this cache along with the TLB. Each slot is a state machine with these states: IDLE, DIR_REQ (issue the directory read), DIR_WAIT (await it), LEAF_REQ (issue the leaf read), LEAF_WAIT (await it), ACC_WR (post a write that sets the accessed bit), HOLD (a speculative walk waits for use) and DONE (present the result). The transitions are:
- IDLE→LEAF_REQ on a directory-cache hit, or IDLE→DIR_REQ on a miss.
- DIR_REQ→DIR_WAIT on grant.
- DIR_WAIT→LEAF_REQ for a present directory entry, or DIR_WAIT→DONE with a fault for an absent one.
- LEAF_REQ→LEAF_WAIT on grant.
- LEAF_WAIT→DONE with a fault for an absent leaf. A present leaf goes to ACC_WR if its accessed bit is clear, then to HOLD if the walk is speculative, and otherwise to DONE.
- ACC_WR→HOLD or ACC_WR→DONE on grant.
- HOLD→DONE when the use input names the walk's page.
- ACC_WR→DONE or HOLD→DONE with a mis-speculation when a snooped store hits the loaded leaf entry.
- DONE→IDLE when the result is presented.

Top module: `ptw_top`

## Requirements
- R1: A walk that misses the directory cache reads the directory entry at {dir_base, vpn[19:10], 2'b00}, then the leaf entry at {dir_entry[31:12], vpn[9:0], 2'b00}. It reports res_kind 0 (fill) with res_pfn equal to leaf_entry[31:12]. An entry is present when bit 0 is set.
- R2: A walk whose directory index matches a cached present directory entry issues no directory read. It reads only the leaf entry and fills correctly.
- R3: An absent directory entry or an absent leaf entry gives res_kind 1 (fault) and no fill. No absent entry is cached, so a retry after the table is fixed reads again from memory and fills.
- R4: A one-cycle flush pulse empties the directory cache, so the next walk through any index reads its directory entry from memory again.
- R5: Two walks can be in flight together with memory tags 0 and 1. Responses may return in either order, each walk completes with its own correct result, and the faster walk may report first.
- R6: When a present leaf entry has accessed bit 5 clear, one write of the entry with bit 5 set goes to the leaf address before the fill. A leaf entry with bit 5 already set causes no write.
- R7: A speculative walk (req_spec=1) that loads a present leaf holds its fill until use_valid arrives with a matching use_vpn, and then reports a fill.
- R8: A speculative walk whose loaded leaf address receives a snooped store before use reports res_kind 2 (mis-speculation) and no fill. A later use for that page produces no result. A snooped store to any other address has no effect.
- R9: After reset, req_ready is 1, mreq_valid is 0 and res_valid is 0.
- R10: The directory cache holds 4 entries replaced in round-robin order. After five distinct indices are cached in turn, the first one must be read again from memory, while the third still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 20 | Frame number of the directory page |
| flush | input | 1 | Empties the directory-entry cache |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | A walk slot is free; the request is taken when both are high |
| req_vpn | input | 20 | Virtual page number: bits 19:10 directory index, bits 9:0 table index |
| req_spec | input | 1 | Request is speculative |
| use_valid | input | 1 | A translation has been used architecturally |
| use_vpn | input | 20 | Page number of that use |
| snoop_valid | input | 1 | A store to memory was observed |
| snoop_addr | input | 32 | Byte address of that store |
| mreq_valid | output | 1 | Memory request present |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_we | output | 1 | 1 for a posted write, 0 for a read |
| mreq_tag | output | 1 | Walk slot issuing the request |
| mreq_addr | output | 32 | Byte address of the entry |
| mreq_wdata | output | 32 | Write data |
| mrsp_valid | input | 1 | Read response present |
| mrsp_tag | input | 1 | Walk slot the response belongs to |
| mrsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Result present for one cycle |
| res_kind | output | 2 | 0 fill, 1 fault, 2 mis-speculation |
| res_vpn | output | 20 | Page number the result belongs to |
| res_pfn | output | 20 | Physical frame, meaningful for a fill |

## Verification
A stale or duplicated directory-cache entry shows up in the memory traffic that follows the next request. A directory read that should have been skipped appears, or a skipped read leads to a wrong frame on res_pfn, within a few cycles of the walk's start. A slot left in the wrong state, or a response routed to the wrong tag, shows up as a result whose kind or frame does not match its page number, or as a page that never reports. A speculative walk that leaves HOLD too early reports a fill before any use arrives. One that misses a snoop reports a fill where a mis-speculation belongs. Both are visible on the result port within a cycle of the deciding input.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PRESENT_BIT  = 0;
    localparam int ACCESSED_BIT = 5;

    typedef enum logic [1:0] {
        RES_FILL    = 2'd0,
        RES_FAULT   = 2'd1,
        RES_MISSPEC = 2'd2
    } res_kind_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DIR_REQ,
        W_DIR_WAIT,
        W_LEAF_REQ,
        W_LEAF_WAIT,
        W_ACC_WR,
        W_HOLD,
        W_DONE
    } walk_state_e;

endpackage

// File: rtl/ptw_dir_cache.sv
module ptw_dir_cache #(
    parameter int IDX_W   = 10,
    parameter int BASE_W  = 20,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              look_hit,
    output logic [BASE_W-1:0] look_base,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [BASE_W-1:0] fill_base
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [IDX_W-1:0]   tag_q  [ENTRIES];
    logic [BASE_W-1:0]  base_q [ENTRIES];
    logic [PTR_W-1:0]   rr_q;
    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] fill_match;

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign look_match[e] = vld_q[e] && (tag_q[e] == look_idx);
            assign fill_match[e] = vld_q[e] && (tag_q[e] == fill_idx);
        end
    endgenerate

    always_comb begin
        look_hit  = |look_match;
        look_base = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (look_match[e]) look_base = base_q[e];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_valid) begin
            if (|fill_match) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    if (fill_match[e]) base_q[e] <= fill_base;
                end
            end else begin
                vld_q[rr_q]  <= 1'b1;
                tag_q[rr_q]  <= fill_idx;
                base_q[rr_q] <= fill_base;
                rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    // R4: nothing survives a flush
    a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !look_hit);

    // R10: an index is held in at most one way
    a_r10_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_match));

endmodule

// File: rtl/ptw_walk_slot.sv
module ptw_walk_slot
    import ptw_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-OFF_W-1:0]     dir_base,
    input  logic                        start,
    input  logic [2*IDX_W-1:0]          start_vpn,
    input  logic                        start_spec,
    input  logic                        start_hit,
    input  logic [ADDR_W-OFF_W-1:0]     start_base,
    output logic                        idle,
    output logic                        mem_want,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [ADDR_W-1:0]           mem_wdata,
    input  logic                        mem_grant,
    input  logic                        rsp_valid,
    input  logic [ADDR_W-1:0]           rsp_data,
    output logic                        cfill_valid,
    output logic [IDX_W-1:0]            cfill_idx,
    output logic [ADDR_W-OFF_W-1:0]     cfill_base,
    input  logic                        snoop_valid,
    input  logic [ADDR_W-1:0]           snoop_addr,
    input  logic                        use_valid,
    input  logic [2*IDX_W-1:0]          use_vpn,
    output logic                        done,
    output res_kind_e                   done_kind,
    output logic [2*IDX_W-1:0]          done_vpn,
    output logic [ADDR_W-OFF_W-1:0]     done_pfn,
    input  logic                        done_ack
);
    localparam int VPN_W = 2 * IDX_W;
    localparam int PFN_W = ADDR_W - OFF_W;

    walk_state_e       state_q, state_d;
    res_kind_e         kind_q, kind_d;
    logic [VPN_W-1:0]  vpn_q;
    logic              spec_q;
    logic [PFN_W-1:0]  base_q;
    logic [ADDR_W-1:0] pte_q;
    logic              leaf_seen_q;
    logic              poison_q;

    logic [IDX_W-1:0]  dir_idx, tbl_idx;
    logic [ADDR_W-1:0] dir_addr, leaf_addr;
    logic              snoop_hit, use_hit;

    assign dir_idx   = vpn_q[VPN_W-1:IDX_W];
    assign tbl_idx   = vpn_q[IDX_W-1:0];
    assign dir_addr  = {dir_base, dir_idx, 2'b00};
    assign leaf_addr = {base_q, tbl_idx, 2'b00};
    assign snoop_hit = snoop_valid && spec_q && leaf_seen_q
                     && (snoop_addr[ADDR_W-1:2] == leaf_addr[ADDR_W-1:2]);
    assign use_hit   = use_valid && (use_vpn == vpn_q);

    // state register and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= W_IDLE;
            kind_q      <= RES_FILL;
            leaf_seen_q <= 1'b0;
            poison_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            if (state_q == W_IDLE && start) begin
                vpn_q       <= start_vpn;
                spec_q      <= start_spec;
                base_q      <= start_base;
                leaf_seen_q <= 1'b0;
                poison_q    <= 1'b0;
            end else begin
                if (snoop_hit) poison_q <= 1'b1;
                if (state_q == W_DIR_WAIT && rsp_valid)
                    base_q <= rsp_data[ADDR_W-1:OFF_W];
                if (state_q == W_LEAF_WAIT && rsp_valid) begin
                    pte_q       <= rsp_data;
                    leaf_seen_q <= rsp_data[PRESENT_BIT];
                end
            end
        end
    end

    // next state and result kind
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            W_IDLE: begin
                if (start) begin
                    state_d = start_hit ? W_LEAF_REQ : W_DIR_REQ;
                    kind_d  = RES_FILL;
                end
            end
            W_DIR_REQ:  if (mem_grant) state_d = W_DIR_WAIT;
            W_DIR_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_data[PRESENT_BIT]) state_d = W_LEAF_REQ;
                    else begin
                        state_d = W_DONE;
                        kind_d  = RES_FAULT;
                    end
                end
            end
            W_LEAF_REQ: if (mem_grant) state_d = W_LEAF_WAIT;
            W_LEAF_WAIT: begin
                if (rsp_valid) begin
                    if (!rsp_data[PRESENT_BIT]) begin
                        state_d = W_DONE;
                        kind_d  = RES_FAULT;
                    end else if (!rsp_data[ACCESSED_BIT]) state_d = W_ACC_WR;
                    else state_d = spec_q ? W_HOLD : W_DONE;
                end
            end
            W_ACC_WR: begin
                if (poison_q) begin
                    state_d = W_DONE;
                    kind_d  = RES_MISSPEC;
                end else if (mem_grant) state_d = spec_q ? W_HOLD : W_DONE;
            end
            W_HOLD: begin
                if (poison_q) begin
                    state_d = W_DONE;
                    kind_d  = RES_MISSPEC;
                end else if (use_hit) state_d = W_DONE;
            end
            W_DONE: if (done_ack) state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle        = (state_q == W_IDLE);
        mem_want    = (state_q == W_DIR_REQ) || (state_q == W_LEAF_REQ)
                   || (state_q == W_ACC_WR && !poison_q);
        mem_we      = (state_q == W_ACC_WR);
        mem_addr    = (state_q == W_DIR_REQ) ? dir_addr : leaf_addr;
        mem_wdata   = pte_q | (ADDR_W'(1) << ACCESSED_BIT);
        cfill_valid = (state_q == W_DIR_WAIT) && rsp_valid && rsp_data[PRESENT_BIT];
        cfill_idx   = dir_idx;
        cfill_base  = rsp_data[ADDR_W-1:OFF_W];
        done        = (state_q == W_DONE);
        done_kind   = kind_q;
        done_vpn    = vpn_q;
        done_pfn    = pte_q[ADDR_W-1:OFF_W];
    end

    // R7: only a speculative walk parks awaiting use
    a_r7_hold_is_spec: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_HOLD) |-> spec_q);

    // R6: the set-accessed write is only for a leaf that lacked the bit
    a_r6_write_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_ACC_WR) |-> (leaf_seen_q && !pte_q[ACCESSED_BIT]));

    // R8: mis-speculation is reported only for speculative walks
    a_r8_misspec_spec: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_DONE && kind_q == RES_MISSPEC) |-> spec_q);

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int IDX_W      = 10,
    parameter int OFF_W      = 12,
    parameter int ADDR_W     = 32,
    parameter int NUM_WALKS  = 2,
    parameter int DC_ENTRIES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-OFF_W-1:0] dir_base,
    input  logic                    flush,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [2*IDX_W-1:0]      req_vpn,
    input  logic                    req_spec,
    input  logic                    use_valid,
    input  logic [2*IDX_W-1:0]      use_vpn,
    input  logic                    snoop_valid,
    input  logic [ADDR_W-1:0]       snoop_addr,
    output logic                    mreq_valid,
    input  logic                    mreq_ready,
    output logic                    mreq_we,
    output logic [$clog2(NUM_WALKS)-1:0] mreq_tag,
    output logic [ADDR_W-1:0]       mreq_addr,
    output logic [ADDR_W-1:0]       mreq_wdata,
    input  logic                    mrsp_valid,
    input  logic [$clog2(NUM_WALKS)-1:0] mrsp_tag,
    input  logic [ADDR_W-1:0]       mrsp_data,
    output logic                    res_valid,
    output logic [1:0]              res_kind,
    output logic [2*IDX_W-1:0]      res_vpn,
    output logic [ADDR_W-OFF_W-1:0] res_pfn
);
    localparam int VPN_W = 2 * IDX_W;
    localparam int PFN_W = ADDR_W - OFF_W;
    localparam int TAG_W = $clog2(NUM_WALKS);

    logic [NUM_WALKS-1:0] s_idle, s_start, s_want, s_we, s_grant, s_rsp, s_cfv, s_done, s_ack;
    logic [ADDR_W-1:0]    s_addr  [NUM_WALKS];
    logic [ADDR_W-1:0]    s_wdata [NUM_WALKS];
    logic [IDX_W-1:0]     s_cfidx [NUM_WALKS];
    logic [PFN_W-1:0]     s_cfbase[NUM_WALKS];
    res_kind_e            s_kind  [NUM_WALKS];
    logic [VPN_W-1:0]     s_vpn   [NUM_WALKS];
    logic [PFN_W-1:0]     s_pfn   [NUM_WALKS];

    logic             dc_hit, dc_fill;
    logic [PFN_W-1:0] dc_base, dc_fill_base;
    logic [IDX_W-1:0] dc_fill_idx;

    ptw_dir_cache #(.IDX_W(IDX_W), .BASE_W(PFN_W), .ENTRIES(DC_ENTRIES)) u_dcache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .look_idx(req_vpn[VPN_W-1:IDX_W]), .look_hit(dc_hit), .look_base(dc_base),
        .fill_valid(dc_fill), .fill_idx(dc_fill_idx), .fill_base(dc_fill_base)
    );

    generate
        for (genvar g = 0; g < NUM_WALKS; g++) begin : g_slot
            assign s_rsp[g] = mrsp_valid && (mrsp_tag == TAG_W'(g));
            ptw_walk_slot #(.IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_slot (
                .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
                .start(s_start[g]), .start_vpn(req_vpn), .start_spec(req_spec),
                .start_hit(dc_hit), .start_base(dc_base), .idle(s_idle[g]),
                .mem_want(s_want[g]), .mem_we(s_we[g]), .mem_addr(s_addr[g]),
                .mem_wdata(s_wdata[g]), .mem_grant(s_grant[g]),
                .rsp_valid(s_rsp[g]), .rsp_data(mrsp_data),
                .cfill_valid(s_cfv[g]), .cfill_idx(s_cfidx[g]), .cfill_base(s_cfbase[g]),
                .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
                .use_valid(use_valid), .use_vpn(use_vpn),
                .done(s_done[g]), .done_kind(s_kind[g]), .done_vpn(s_vpn[g]),
                .done_pfn(s_pfn[g]), .done_ack(s_ack[g])
            );
        end
    endgenerate

    // request steering, memory arbitration, cache fill and result selection
    always_comb begin
        logic got_s, got_m, got_d;
        got_s = 1'b0; got_m = 1'b0; got_d = 1'b0;
        s_start = '0; s_grant = '0; s_ack = '0;
        req_ready  = |s_idle;
        mreq_valid = 1'b0; mreq_we = 1'b0; mreq_tag = '0;
        mreq_addr  = '0;   mreq_wdata = '0;
        dc_fill = |s_cfv; dc_fill_idx = '0; dc_fill_base = '0;
        res_valid = 1'b0; res_kind = RES_FILL; res_vpn = '0; res_pfn = '0;
        for (int i = 0; i < NUM_WALKS; i++) begin
            if (!got_s && s_idle[i]) begin
                s_start[i] = req_valid;
                got_s = 1'b1;
            end
            if (!got_m && s_want[i]) begin
                mreq_valid = 1'b1;
                mreq_we    = s_we[i];
                mreq_tag   = TAG_W'(i);
                mreq_addr  = s_addr[i];
                mreq_wdata = s_wdata[i];
                s_grant[i] = mreq_ready;
                got_m = 1'b1;
            end
            if (s_cfv[i]) begin
                dc_fill_idx  = s_cfidx[i];
                dc_fill_base = s_cfbase[i];
            end
            if (!got_d && s_done[i]) begin
                res_valid = 1'b1;
                res_kind  = s_kind[i];
                res_vpn   = s_vpn[i];
                res_pfn   = s_pfn[i];
                s_ack[i]  = 1'b1;
                got_d = 1'b1;
            end
        end
    end

    // R3: a directory entry enters the cache only when memory returned it present
    a_r3_fill_present: assert property (@(posedge clk) disable iff (!rst_n)
        dc_fill |-> mrsp_valid && mrsp_data[PRESENT_BIT]);

    // R5: a response is only accepted by a slot that is mid-walk
    a_r5_rsp_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_rsp) |-> ((s_rsp & s_idle) == '0));

endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;

    localparam logic [19:0] DIRB = 20'h00010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        flush = 0, req_valid = 0, req_spec = 0, use_valid = 0, snoop_valid = 0;
    logic [19:0] req_vpn = '0, use_vpn = '0;
    logic [31:0] snoop_addr = '0;
    logic        req_ready, mreq_valid, mreq_we, res_valid;
    logic        mreq_ready = 1'b1;
    logic [0:0]  mreq_tag;
    logic [31:0] mreq_addr, mreq_wdata;
    logic        mrsp_valid = 0;
    logic [0:0]  mrsp_tag = '0;
    logic [31:0] mrsp_data = '0;
    logic [1:0]  res_kind;
    logic [19:0] res_vpn, res_pfn;

    ptw_top u0 (
        .clk(clk), .rst_n(rst_n), .dir_base(DIRB), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_spec(req_spec),
        .use_valid(use_valid), .use_vpn(use_vpn),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_we(mreq_we),
        .mreq_tag(mreq_tag), .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
        .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag), .mrsp_data(mrsp_data),
        .res_valid(res_valid), .res_kind(res_kind), .res_vpn(res_vpn), .res_pfn(res_pfn)
    );

    int checks = 0, failures = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [31:0]];
    int unsigned lat [2];
    logic [1:0]  pend_v = '0;
    int unsigned pend_cnt [2];
    logic [31:0] pend_addr [2];
    logic        responded;
    int          dir_reads = 0, wr_count = 0;
    logic [31:0] last_wa = '0, last_wd = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        mrsp_valid = 1'b0;
        if (!rst_n) begin
            pend_v = '0;
        end else begin
            responded = 1'b0;
            for (int t = 0; t < 2; t++) begin
                if (pend_v[t]) begin
                    if (pend_cnt[t] > 1) pend_cnt[t]--;
                    else if (!responded) begin
                        mrsp_valid = 1'b1;
                        mrsp_tag   = 1'(t);
                        mrsp_data  = rd(pend_addr[t]);
                        pend_v[t]  = 1'b0;
                        responded  = 1'b1;
                    end
                end
            end
            if (mreq_valid) begin
                if (mreq_we) begin
                    mem[mreq_addr] = mreq_wdata;
                    wr_count++;
                    last_wa = mreq_addr;
                    last_wd = mreq_wdata;
                end else begin
                    pend_v[mreq_tag]    = 1'b1;
                    pend_cnt[mreq_tag]  = lat[mreq_tag];
                    pend_addr[mreq_tag] = mreq_addr;
                    if (mreq_addr[31:12] == DIRB) dir_reads++;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [19:0] vpn;
        logic [1:0]  kind;
        logic [19:0] pfn;
        string       req;
    } exp_t;
    exp_t        sb[$];
    logic [19:0] done_order[$];
    int          res_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            int idx;
            idx = -1;
            res_cnt++;
            done_order.push_back(res_vpn);
            foreach (sb[k]) if (idx < 0 && sb[k].vpn == res_vpn) idx = k;
            if (idx < 0) check(1'b0, "unexpected result (R8/R3)", {12'h0, res_vpn}, 32'h0);
            else begin
                check(res_kind == sb[idx].kind, sb[idx].req, {30'h0, res_kind}, {30'h0, sb[idx].kind});
                if (sb[idx].kind == 2'd0)
                    check(res_pfn == sb[idx].pfn, sb[idx].req, {12'h0, res_pfn}, {12'h0, sb[idx].pfn});
                sb.delete(idx);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic walk(input logic [19:0] vpn, input logic spec, input logic [1:0] kind,
                        input logic [19:0] pfn, input string req);
        exp_t e;
        e.vpn = vpn; e.kind = kind; e.pfn = pfn; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_vpn = vpn; req_spec = spec;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_spec = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_use(input logic [19:0] vpn);
        @(negedge clk); use_valid = 1'b1; use_vpn = vpn;
        @(negedge clk); use_valid = 1'b0;
    endtask

    task automatic pulse_snoop(input logic [31:0] a);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk); snoop_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    function automatic logic [31:0] dir_a(input logic [9:0] i);
        return {DIRB, i, 2'b00};
    endfunction
    function automatic logic [31:0] leaf_a(input logic [19:0] t, input logic [9:0] i);
        return {t, i, 2'b00};
    endfunction

    // ---------------- tests ----------------
    task automatic run_tests();
        int d0, w0, r0;
        lat[0] = 1; lat[1] = 1;
        mem[dir_a(10'd1)]             = {20'h00020, 12'h001};
        mem[leaf_a(20'h20, 10'd3)]    = {20'hABCDE, 12'h021};
        mem[leaf_a(20'h20, 10'd4)]    = {20'h12345, 12'h021};
        mem[leaf_a(20'h20, 10'd5)]    = {20'h55555, 12'h001};
        mem[dir_a(10'd2)]             = 32'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 req_ready", {31'h0, req_ready}, 32'h1);
        check(mreq_valid == 1'b0, "R9 mreq_valid", {31'h0, mreq_valid}, 32'h0);
        check(res_valid == 1'b0, "R9 res_valid", {31'h0, res_valid}, 32'h0);

        // R1: full walk, accessed already set
        d0 = dir_reads; w0 = wr_count;
        walk({10'd1, 10'd3}, 1'b0, 2'd0, 20'hABCDE, "R1 fill");
        drain();
        check(dir_reads == d0 + 1, "R1 dir read", dir_reads, d0 + 1);
        check(wr_count == w0, "R6 no write when accessed set", wr_count, w0);

        // R2: directory cache hit
        d0 = dir_reads;
        walk({10'd1, 10'd4}, 1'b0, 2'd0, 20'h12345, "R2 fill on hit");
        drain();
        check(dir_reads == d0, "R2 dir read skipped", dir_reads, d0);

        // R6: accessed bit clear
        w0 = wr_count;
        walk({10'd1, 10'd5}, 1'b0, 2'd0, 20'h55555, "R6 fill");
        drain();
        check(wr_count == w0 + 1, "R6 write count", wr_count, w0 + 1);
        check(last_wa == leaf_a(20'h20, 10'd5), "R6 write addr", last_wa, leaf_a(20'h20, 10'd5));
        check(last_wd == 32'h55555021, "R6 write data", last_wd, 32'h55555021);

        // R3: leaf fault then retry
        walk({10'd1, 10'd6}, 1'b0, 2'd1, 20'h0, "R3 leaf fault");
        drain();
        mem[leaf_a(20'h20, 10'd6)] = {20'h66666, 12'h021};
        walk({10'd1, 10'd6}, 1'b0, 2'd0, 20'h66666, "R3 leaf retry");
        drain();

        // R3: directory fault, not cached
        d0 = dir_reads;
        walk({10'd2, 10'd0}, 1'b0, 2'd1, 20'h0, "R3 dir fault");
        drain();
        mem[dir_a(10'd2)]          = {20'h00030, 12'h001};
        mem[leaf_a(20'h30, 10'd0)] = {20'h77777, 12'h021};
        walk({10'd2, 10'd0}, 1'b0, 2'd0, 20'h77777, "R3 dir retry");
        drain();
        check(dir_reads == d0 + 2, "R3 absent dir not cached", dir_reads, d0 + 2);

        // R4: flush
        pulse_flush();
        d0 = dir_reads;
        walk({10'd1, 10'd3}, 1'b0, 2'd0, 20'hABCDE, "R4 fill after flush");
        drain();
        check(dir_reads == d0 + 1, "R4 dir reread", dir_reads, d0 + 1);

        // R5: two walks, out-of-order responses
        mem[dir_a(10'd3)]          = {20'h00040, 12'h001};
        mem[dir_a(10'd4)]          = {20'h00041, 12'h001};
        mem[leaf_a(20'h40, 10'd1)] = {20'h0AAAA, 12'h021};
        mem[leaf_a(20'h41, 10'd2)] = {20'h0BBBB, 12'h021};
        lat[0] = 8; lat[1] = 1;
        done_order.delete();
        walk({10'd3, 10'd1}, 1'b0, 2'd0, 20'h0AAAA, "R5 slow walk");
        walk({10'd4, 10'd2}, 1'b0, 2'd0, 20'h0BBBB, "R5 fast walk");
        drain();
        lat[0] = 1;
        check(done_order.size() == 2, "R5 result count", done_order.size(), 2);
        if (done_order.size() > 0)
            check(done_order[0] == {10'd4, 10'd2}, "R5 fast walk first",
                  {12'h0, done_order[0]}, {12'h0, 10'd4, 10'd2});

        // R10: round-robin replacement
        pulse_flush();
        for (int k = 5; k < 10; k++) begin
            mem[dir_a(10'(k))] = {20'h00050 + 20'(k), 12'h001};
            mem[leaf_a(20'h00050 + 20'(k), 10'd0)] = {20'h60000 + 20'(k), 12'h021};
        end
        for (int k = 5; k < 10; k++) begin
            walk({10'(k), 10'd0}, 1'b0, 2'd0, 20'h60000 + 20'(k), "R10 fill");
            drain();
        end
        d0 = dir_reads;
        walk({10'd5, 10'd0}, 1'b0, 2'd0, 20'h60005, "R10 evicted");
        drain();
        check(dir_reads == d0 + 1, "R10 first index evicted", dir_reads, d0 + 1);
        d0 = dir_reads;
        walk({10'd7, 10'd0}, 1'b0, 2'd0, 20'h60007, "R10 kept");
        drain();
        check(dir_reads == d0, "R10 third index kept", dir_reads, d0);

        // R7: speculative fill waits for use
        r0 = res_cnt;
        walk({10'd1, 10'd3}, 1'b1, 2'd0, 20'hABCDE, "R7 spec fill");
        repeat (20) @(negedge clk);
        check(res_cnt == r0, "R7 held before use", res_cnt, r0);
        pulse_use({10'd1, 10'd3});
        drain();
        check(res_cnt == r0 + 1, "R7 released by use", res_cnt, r0 + 1);

        // R8: snoop on loaded leaf entry
        r0 = res_cnt;
        walk({10'd1, 10'd4}, 1'b1, 2'd2, 20'h0, "R8 misspec");
        repeat (20) @(negedge clk);
        pulse_snoop(leaf_a(20'h20, 10'd7));
        repeat (5) @(negedge clk);
        check(res_cnt == r0, "R8 other address ignored", res_cnt, r0);
        pulse_snoop(leaf_a(20'h20, 10'd4));
        drain();
        pulse_use({10'd1, 10'd4});
        repeat (5) @(negedge clk);
        check(res_cnt == r0 + 1, "R8 single result, no fill", res_cnt, r0 + 1);
    endtask

    initial begin
        bit timeout;
        timeout = 1'b0;
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule